// File: doc/BRIEF.md
# Interrupt acceptance and flag update

This block owns the processor status word and decides, once per clock, whether an incoming interrupt is taken. Three request sources arrive together: a maskable hardware request carrying a 3-bit priority level and a vector, a non-maskable request, and a software interrupt request carrying its vector number. A taken request produces a one-cycle acknowledge with the chosen vector. In the same cycle the block clears the global interrupt enable, clears the stack-select bit where the source calls for it, and raises the processor level to match a taken maskable request.

The same register also takes condition results from the ALU (carry, zero, sign, overflow) and a full-word write from the datapath. When these sources meet in one cycle, a fixed merge order applies. Saving the return address and status, and fetching the vector, belong to neighbouring logic, which starts from the acknowledge pulse.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset every status bit reads 0, so interrupts are disabled, the interrupt stack is selected and the level is 0. The acknowledge output stays low until a request is taken.
- R2: A maskable request is taken only when the enable bit is 1 and its level is strictly greater than the processor level. An equal or lower level, or enable 0, gives no acknowledge.
- R3: Every taken request, whatever its source, clears the enable bit on the same edge that raises the acknowledge.
- R4: A taken maskable request loads the processor level with the request's level, clears stack-select and acknowledges with the request's vector. The acknowledge appears one clock after the request is sampled.
- R5: A non-maskable request is taken whatever the enable bit and the level. It acknowledges with the fixed vector NMI_VEC (default 1), clears stack-select and leaves the level unchanged.
- R6: A non-maskable request wins over a maskable and a software request presented in the same cycle.
- R7: A software request is taken whatever the enable bit and the level, and leaves the level unchanged. Vectors 0 to 31 clear stack-select. Vectors 32 and above leave it as it was.
- R8: When an acceptable maskable request and a software request arrive together with no non-maskable request, the maskable one is taken and the software one gets no acknowledge.
- R9: An ALU update writes carry from its carry input, zero when the result is all zeros, sign from the result's top bit, and overflow from its overflow input. Each bit is 0 otherwise.
- R10: The status word has 11 bits: carry 0, debug 1, zero 2, sign 3, bank 4, overflow 5, enable 6, stack-select 7, and level in bits 10:8. A full write loads every field except debug, which always reads 0.
- R11: Within one cycle, an ALU update overrides a full write on carry, zero, sign and overflow. Acceptance overrides both on enable, stack-select and level. Acceptance is decided from the status held before that cycle's edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mreq_i | input | 1 | Maskable request present |
| mreq_lvl_i | input | 3 | Maskable request priority level |
| mreq_vec_i | input | VEC_W | Maskable request vector |
| nmi_i | input | 1 | Non-maskable request |
| swi_i | input | 1 | Software interrupt request |
| swi_vec_i | input | VEC_W | Software interrupt vector number |
| alu_en_i | input | 1 | ALU condition update strobe |
| alu_carry_i | input | 1 | ALU carry/borrow out |
| alu_res_i | input | DATA_W | ALU result |
| alu_ovf_i | input | 1 | ALU overflow |
| fw_en_i | input | 1 | Full status-word write strobe |
| fw_data_i | input | 11 | Status-word write data |
| ack_o | output | 1 | One-cycle acknowledge of a taken request |
| ack_vec_o | output | VEC_W | Vector of the last taken request |
| flags_o | output | 11 | Current status word |

## Verification
Every field of the status word goes straight to flags_o, so a wrong enable, stack-select or level bit shows up one clock after the edge that produced it. A wrong bit also changes which later requests are acknowledged. A mistake in the arbitration shows up on the very next cycle as a missing acknowledge, an extra one, or a wrong vector. A merge-order error between write, ALU and acceptance shows up only when those sources coincide, so the bench drives such collisions on purpose and compares the whole status word after each one.

// File: rtl/irq_flag_pkg.sv
`timescale 1ns/1ps
package irq_flag_pkg;
  localparam int FLG_W = 11;
  localparam int LVL_W = 3;
  localparam int B_C   = 0;
  localparam int B_D   = 1;
  localparam int B_Z   = 2;
  localparam int B_S   = 3;
  localparam int B_BNK = 4;
  localparam int B_O   = 5;
  localparam int B_IE  = 6;
  localparam int B_U   = 7;
  localparam int B_LVL = 8;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_MASK = 2'd2,
    SRC_SOFT = 2'd3
  } irq_src_e;
endpackage

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick
  import irq_flag_pkg::*;
#(
  parameter int VEC_W         = 6,
  parameter int NMI_VEC       = 1,
  parameter int SWI_STK_LIMIT = 32
) (
  input  logic             ie_i,
  input  logic [LVL_W-1:0] cur_lvl_i,
  input  logic             mreq_i,
  input  logic [LVL_W-1:0] mreq_lvl_i,
  input  logic [VEC_W-1:0] mreq_vec_i,
  input  logic             nmi_i,
  input  logic             swi_i,
  input  logic [VEC_W-1:0] swi_vec_i,
  output logic             take_o,
  output irq_src_e         src_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             clr_stk_o
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

  logic mask_ok;
  logic swi_low;

  always_comb begin
    mask_ok = mreq_i && ie_i && (mreq_lvl_i > cur_lvl_i);
    swi_low = int'(swi_vec_i) < SWI_STK_LIMIT;
    take_o    = 1'b0;
    src_o     = SRC_NONE;
    vec_o     = '0;
    clr_stk_o = 1'b0;
    if (nmi_i) begin
      take_o    = 1'b1;
      src_o     = SRC_NMI;
      vec_o     = NMI_V;
      clr_stk_o = 1'b1;
    end else if (mask_ok) begin
      take_o    = 1'b1;
      src_o     = SRC_MASK;
      vec_o     = mreq_vec_i;
      clr_stk_o = 1'b1;
    end else if (swi_i) begin
      take_o    = 1'b1;
      src_o     = SRC_SOFT;
      vec_o     = swi_vec_i;
      clr_stk_o = swi_low;
    end
  end
endmodule

// File: rtl/flag_next.sv
`timescale 1ns/1ps
module flag_next
  import irq_flag_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [FLG_W-1:0]  cur_i,
  input  logic              fw_en_i,
  input  logic [FLG_W-1:0]  fw_data_i,
  input  logic              alu_en_i,
  input  logic              alu_carry_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_ovf_i,
  input  logic              take_i,
  input  irq_src_e          src_i,
  input  logic              clr_stk_i,
  input  logic [LVL_W-1:0]  new_lvl_i,
  output logic [FLG_W-1:0]  nxt_o
);
  always_comb begin
    nxt_o = cur_i;
    if (fw_en_i) begin
      nxt_o = fw_data_i;
    end
    if (alu_en_i) begin
      nxt_o[B_C] = alu_carry_i;
      nxt_o[B_Z] = (alu_res_i == '0);
      nxt_o[B_S] = alu_res_i[DATA_W-1];
      nxt_o[B_O] = alu_ovf_i;
    end
    if (take_i) begin
      nxt_o[B_IE] = 1'b0;
      if (clr_stk_i) begin
        nxt_o[B_U] = 1'b0;
      end
      if (src_i == SRC_MASK) begin
        nxt_o[B_LVL +: LVL_W] = new_lvl_i;
      end
    end
    nxt_o[B_D] = 1'b0;
  end
endmodule

// File: rtl/irq_flag_ctrl.sv
`timescale 1ns/1ps
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int DATA_W        = 16,
  parameter int VEC_W         = 6,
  parameter int NMI_VEC       = 1,
  parameter int SWI_STK_LIMIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mreq_i,
  input  logic [2:0]        mreq_lvl_i,
  input  logic [VEC_W-1:0]  mreq_vec_i,
  input  logic              nmi_i,
  input  logic              swi_i,
  input  logic [VEC_W-1:0]  swi_vec_i,
  input  logic              alu_en_i,
  input  logic              alu_carry_i,
  input  logic [DATA_W-1:0] alu_res_i,
  input  logic              alu_ovf_i,
  input  logic              fw_en_i,
  input  logic [10:0]       fw_data_i,
  output logic              ack_o,
  output logic [VEC_W-1:0]  ack_vec_o,
  output logic [10:0]       flags_o
);
  localparam logic [VEC_W-1:0] NMI_V = VEC_W'(NMI_VEC);

  logic [1:0]       rst_pipe;
  logic             rst_s_n;
  logic             live_q;
  logic [FLG_W-1:0] flag_q, flag_d;
  logic             ack_q, ack_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             take;
  irq_src_e         src;
  logic [VEC_W-1:0] pick_vec;
  logic             clr_stk;

  // reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  irq_pick #(
    .VEC_W(VEC_W), .NMI_VEC(NMI_VEC), .SWI_STK_LIMIT(SWI_STK_LIMIT)
  ) u_pick (
    .ie_i       (flag_q[B_IE]),
    .cur_lvl_i  (flag_q[B_LVL +: LVL_W]),
    .mreq_i     (mreq_i),
    .mreq_lvl_i (mreq_lvl_i),
    .mreq_vec_i (mreq_vec_i),
    .nmi_i      (nmi_i),
    .swi_i      (swi_i),
    .swi_vec_i  (swi_vec_i),
    .take_o     (take),
    .src_o      (src),
    .vec_o      (pick_vec),
    .clr_stk_o  (clr_stk)
  );

  flag_next #(.DATA_W(DATA_W)) u_next (
    .cur_i       (flag_q),
    .fw_en_i     (fw_en_i),
    .fw_data_i   (fw_data_i),
    .alu_en_i    (alu_en_i),
    .alu_carry_i (alu_carry_i),
    .alu_res_i   (alu_res_i),
    .alu_ovf_i   (alu_ovf_i),
    .take_i      (take),
    .src_i       (src),
    .clr_stk_i   (clr_stk),
    .new_lvl_i   (mreq_lvl_i),
    .nxt_o       (flag_d)
  );

  always_comb begin
    ack_d = take;
    vec_d = vec_q;
    if (take) vec_d = pick_vec;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      flag_q <= '0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
      live_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ack_q  <= ack_d;
      vec_q  <= vec_d;
      live_q <= 1'b1;
    end
  end

  assign ack_o     = ack_q;
  assign ack_vec_o = vec_q;
  assign flags_o   = flag_q;

  p_ack_has_cause_r2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (live_q && ack_q) |-> $past(nmi_i || swi_i ||
      (mreq_i && flag_q[B_IE] && (mreq_lvl_i > flag_q[B_LVL +: LVL_W]))));

  p_ack_clears_ie_r3: assert property (@(posedge clk) disable iff (!rst_s_n)
    ack_q |-> !flag_q[B_IE]);

  p_mask_level_r4: assert property (@(posedge clk) disable iff (!rst_s_n)
    (live_q && $past(mreq_i && !nmi_i && flag_q[B_IE] &&
      (mreq_lvl_i > flag_q[B_LVL +: LVL_W])))
    |-> (ack_q && flag_q[B_LVL +: LVL_W] == $past(mreq_lvl_i) && !flag_q[B_U]));

  p_nmi_first_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    (live_q && $past(nmi_i)) |-> (ack_q && ack_vec_o == NMI_V));

  p_high_swi_keeps_stack_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (live_q && $past(swi_i && !nmi_i && !mreq_i && !fw_en_i &&
      (int'(swi_vec_i) >= SWI_STK_LIMIT)))
    |-> (flag_q[B_U] == $past(flag_q[B_U])));
endmodule

// File: tb/irq_flag_ctrl_bench.sv
`timescale 1ns/1ps
module irq_flag_ctrl_bench;
  localparam int BC = 0, BZ = 2, BS = 3, BO = 5, BIE = 6, BU = 7, BL = 8, BD = 1;
  localparam logic [5:0] NMIV = 6'd1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mreq, nmi, swi, alu_en, alu_c, alu_o, fw_en;
  logic [2:0]  mlvl;
  logic [5:0]  mvec, svec;
  logic [15:0] alu_r;
  logic [10:0] fw_d;
  logic        ack;
  logic [5:0]  ack_vec;
  logic [10:0] flags;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic        q_ack[$];
  logic [5:0]  q_vec[$];
  logic [10:0] q_flg[$];
  string       q_tag[$];
  logic [10:0] model = '0;

  always #4 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n),
    .mreq_i(mreq), .mreq_lvl_i(mlvl), .mreq_vec_i(mvec),
    .nmi_i(nmi), .swi_i(swi), .swi_vec_i(svec),
    .alu_en_i(alu_en), .alu_carry_i(alu_c), .alu_res_i(alu_r), .alu_ovf_i(alu_o),
    .fw_en_i(fw_en), .fw_data_i(fw_d),
    .ack_o(ack), .ack_vec_o(ack_vec), .flags_o(flags)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and queues the expected result
  task automatic step(input logic m, input logic [2:0] ml, input logic [5:0] mv,
                      input logic n, input logic s, input logic [5:0] sv,
                      input logic ae, input logic ac, input logic [15:0] ar,
                      input logic ao, input logic we, input logic [10:0] wd,
                      input string tag);
    logic [10:0] f;
    logic        e_ack;
    logic [5:0]  e_vec;
    @(negedge clk);
    mreq = m; mlvl = ml; mvec = mv; nmi = n; swi = s; svec = sv;
    alu_en = ae; alu_c = ac; alu_r = ar; alu_o = ao; fw_en = we; fw_d = wd;
    f = model;
    if (we) f = wd;
    if (ae) begin
      f[BC] = ac; f[BZ] = (ar == 16'h0); f[BS] = ar[15]; f[BO] = ao;
    end
    e_ack = 1'b0; e_vec = 6'h0;
    if (n) begin
      e_ack = 1'b1; e_vec = NMIV; f[BIE] = 1'b0; f[BU] = 1'b0;
    end else if (m && model[BIE] && (ml > model[BL +: 3])) begin
      e_ack = 1'b1; e_vec = mv; f[BIE] = 1'b0; f[BU] = 1'b0; f[BL +: 3] = ml;
    end else if (s) begin
      e_ack = 1'b1; e_vec = sv; f[BIE] = 1'b0;
      if (sv < 6'd32) f[BU] = 1'b0;
    end
    f[BD] = 1'b0;
    model = f;
    q_ack.push_back(e_ack); q_vec.push_back(e_vec);
    q_flg.push_back(f);     q_tag.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(0, 3'd0, 6'd0, 0, 0, 6'd0, 0, 0, 16'h0, 0, 0, 11'h0, tag);
  endtask

  task automatic wr(input logic [10:0] d, input string tag);
    step(0, 3'd0, 6'd0, 0, 0, 6'd0, 0, 0, 16'h0, 0, 1, d, tag);
  endtask

  // monitor: pops one expected item per clock and compares
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_ack.size() > 0) begin
        logic        e_a;
        logic [5:0]  e_v;
        logic [10:0] e_f;
        string       t;
        e_a = q_ack.pop_front(); e_v = q_vec.pop_front();
        e_f = q_flg.pop_front(); t   = q_tag.pop_front();
        check(ack == e_a, t, "ack", int'(ack), int'(e_a));
        if (e_a) check(ack_vec == e_v, t, "vector", int'(ack_vec), int'(e_v));
        check(flags == e_f, t, "flags", int'(flags), int'(e_f));
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before the sequence ended");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    mreq = 0; mlvl = 0; mvec = 0; nmi = 0; swi = 0; svec = 0;
    alu_en = 0; alu_c = 0; alu_r = 0; alu_o = 0; fw_en = 0; fw_d = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(flags == 11'h0, "R1", "reset flags", int'(flags), 0);
    check(ack == 1'b0, "R1", "reset ack", int'(ack), 0);

    // R10: write with debug set, debug must read 0
    wr(11'h3C2, "R10");
    // R2: equal and lower levels refused
    step(1, 3'd3, 6'd9, 0, 0, 6'd0, 0, 0, 16'h0, 0, 0, 11'h0, "R2");
    step(1, 3'd2, 6'd9, 0, 0, 6'd0, 0, 0, 16'h0, 0, 0, 11'h0, "R2");
    // R4 / R3: higher level taken
    step(1, 3'd5, 6'd20, 0, 0, 6'd0, 0, 0, 16'h0, 0, 0, 11'h0, "R4");
    // R2: enable now 0, level 7 refused
    step(1, 3'd7, 6'd21, 0, 0, 6'd0, 0, 0, 16'h0, 0, 0, 11'h0, "R2");
    // R7: high software vector keeps stack-select, low one clears it
    wr(11'h0C0, "R10");
    step(0, 3'd0, 6'd0, 0, 1, 6'd40, 0, 0, 16'h0, 0, 0, 11'h0, "R7");
    wr(11'h0C0, "R10");
    step(0, 3'd0, 6'd0, 0, 1, 6'd7, 0, 0, 16'h0, 0, 0, 11'h0, "R7");
    // R6: non-maskable beats maskable and software
    wr(11'h0C0, "R10");
    step(1, 3'd4, 6'd12, 1, 1, 6'd50, 0, 0, 16'h0, 0, 0, 11'h0, "R6");
    // R5: non-maskable keeps level, taken with enable 0
    wr(11'h280, "R10");
    step(0, 3'd0, 6'd0, 1, 0, 6'd0, 0, 0, 16'h0, 0, 0, 11'h0, "R5");
    // R9: ALU conditions
    step(0, 3'd0, 6'd0, 0, 0, 6'd0, 1, 1, 16'h0000, 0, 0, 11'h0, "R9");
    step(0, 3'd0, 6'd0, 0, 0, 6'd0, 1, 0, 16'h8000, 1, 0, 11'h0, "R9");
    step(0, 3'd0, 6'd0, 0, 0, 6'd0, 1, 0, 16'h1234, 0, 0, 11'h0, "R9");
    // R11: ALU over write
    step(0, 3'd0, 6'd0, 0, 0, 6'd0, 1, 0, 16'h8000, 0, 1, 11'h03F, "R11");
    // R11: acceptance over write, decided on old flags
    wr(11'h0C0, "R10");
    step(1, 3'd6, 6'd3, 0, 0, 6'd0, 0, 0, 16'h0, 0, 1, 11'h7C1, "R11");
    // R8: maskable beats software
    wr(11'h0C0, "R10");
    step(1, 3'd1, 6'd11, 0, 1, 6'd50, 0, 0, 16'h0, 0, 0, 11'h0, "R8");
    idle("R1");
    idle("R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule